// File: doc/BRIEF.md
# Memory dependence issue scheduler

This block holds the loads and stores that an out-of-order core has in flight and decides when each one may be issued to the memory pipeline. Every entry must clear two separate conditions before it can issue. Its register operands must be ready. Its memory dependence must also be resolved, which means the one older store that an external dependence predictor names as its likely producer has issued. When an entry clears both conditions it joins a ready pool, and the pool always offers its oldest member.

The issue stage takes the offered entry with a valid/ready handshake. When the issued entry is a store, every entry that was waiting on that store is woken in the same step. Entries marked non-speculative ignore both conditions and wait for an explicit release that names their sequence number. A squash removes all state younger than a given sequence number. The predictor tables sit outside the block. Their result reaches the block only as the predicted producer sequence number on the insert port.

Top module: `mem_dep_sched`

## Requirements
- R1: An accepted insert (not non-speculative) with `ins_regs_ready`=1 and no tracked producer is offered on `iss_*` from the next cycle on, provided no older entry is ready.
- R2: An entry inserted with `ins_regs_ready`=0 and no tracked producer stays off the issue port until a register-ready pulse names its sequence number. It becomes ready at the edge that takes that pulse.
- R3: An entry is linked only when `ins_pred_seq` is nonzero and equals the sequence number of a store still held in the block that is not being issued in the same cycle. A linked entry becomes ready once the store has issued and its registers are ready. A predicted value of 0, or one that matches no held store, counts as resolved.
- R4: Every accepted store, non-speculative ones included, can serve as a producer from the cycle after its insert until it issues or is squashed. Inserting a sequence number that equals a held store's is forbidden.
- R5: A non-speculative entry reaches the ready pool only through a release pulse naming its sequence number. Register-ready pulses and store issue have no effect on it.
- R6: The issue port offers the ready entry with the numerically smallest sequence number, with `iss_store`=1 for a store.
- R7: When `iss_valid` and `iss_ready` are both high at an edge, the offered entry leaves the block. If it is a store, each linked dependent whose registers are ready is offered from the next cycle on.
- R8: A squash with value S removes every held entry whose sequence number is greater than S, whether ready or waiting. Links from removed entries disappear with them, so the surviving producer later issues with no stale effect.
- R9: In a squash cycle, inserts, pops, register-ready pulses and releases are ignored, `iss_valid` is 0 and the counters hold.
- R10: The block holds N entries (16 by default). `ins_ready` is 0 while all N are held. An insert offered while full is dropped, even if a pop frees a slot at the same edge.
- R11: Four counters advance on accepted inserts: loads, stores, linked loads and linked stores.
- R12: After reset the block holds nothing: `iss_valid`=0, `ins_ready`=1 and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert pulse |
| ins_ready | output | 1 | A free slot exists |
| ins_seq | input | SEQ_W | Sequence number of the new entry |
| ins_store | input | 1 | 1 for a store, 0 for a load |
| ins_regs_ready | input | 1 | Register operands already available |
| ins_nonspec | input | 1 | Entry waits for an explicit release |
| ins_pred_seq | input | SEQ_W | Predicted producer store, 0 for none |
| regrdy_valid | input | 1 | Register-ready pulse |
| regrdy_seq | input | SEQ_W | Entry whose registers became ready |
| release_valid | input | 1 | Release pulse for a non-speculative entry |
| release_seq | input | SEQ_W | Entry being released |
| iss_valid | output | 1 | An entry is offered for issue |
| iss_ready | input | 1 | Issue stage takes the offered entry |
| iss_seq | output | SEQ_W | Sequence number of the offered entry |
| iss_store | output | 1 | Offered entry is a store |
| sq_valid | input | 1 | Squash pulse |
| sq_seq | input | SEQ_W | Youngest sequence number that survives |
| cnt_loads | output | CNT_W | Accepted load inserts |
| cnt_stores | output | CNT_W | Accepted store inserts |
| cnt_conf_loads | output | CNT_W | Load inserts linked to a producer |
| cnt_conf_stores | output | CNT_W | Store inserts linked to a producer |

## Verification
The hardest situation to reach is a squash that falls between a store and an entry linked to it. The squash removes the dependent while the producer stays. The later issue of that store must then wake nothing, and the freed slot must be reused cleanly. A directed case builds this situation explicitly. The random phase reaches it repeatedly by predicting older sequence numbers, which are often held stores, and by drawing squash points uniformly over the sequence numbers it has already handed out. Same-edge collisions come up often under random traffic: a producer issuing while a dependent is inserted, or an insert arriving while the block is full during a pop.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [1:0] {
    PLACE_READY    = 2'd0,
    PLACE_WAIT_REG = 2'd1,
    PLACE_LINKED   = 2'd2,
    PLACE_HOLD     = 2'd3
  } place_e;

  // Age rule: a larger sequence number is younger (no wrap while held).
  function automatic logic seq_after(input logic [31:0] a, input logic [31:0] b);
    return a > b;
  endfunction

  // Where a freshly accepted entry lands.
  function automatic place_e place_of(input logic nonspec, input logic linked,
                                      input logic regs_ok);
    if (nonspec) return PLACE_HOLD;
    if (linked)  return PLACE_LINKED;
    if (regs_ok) return PLACE_READY;
    return PLACE_WAIT_REG;
  endfunction

endpackage

// File: rtl/mdu_first_set.sv
module mdu_first_set #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mdu_oldest_pick.sv
module mdu_oldest_pick
  import mdu_pkg::*;
#(
  parameter int N     = 16,
  parameter int SEQ_W = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     cand,
  input  logic [SEQ_W-1:0] seqs [N],
  output logic             hit,
  output logic [IW-1:0]    idx
);
  logic [SEQ_W-1:0] best;

  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!hit || seq_after(32'(best), 32'(seqs[i])))) begin
        hit  = 1'b1;
        idx  = IW'(i);
        best = seqs[i];
      end
    end
  end
endmodule

// File: rtl/mdu_event_counters.sv
module mdu_event_counters #(
  parameter int NCNT  = 4,
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCNT-1:0]            inc,
  output logic [NCNT-1:0][CNT_W-1:0] cnt
);
  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)      cnt[g] <= '0;
      else if (inc[g]) cnt[g] <= cnt[g] + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mem_dep_sched.sv
module mem_dep_sched
  import mdu_pkg::*;
#(
  parameter int N     = 16,
  parameter int SEQ_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic             ins_store,
  input  logic             ins_regs_ready,
  input  logic             ins_nonspec,
  input  logic [SEQ_W-1:0] ins_pred_seq,
  input  logic             regrdy_valid,
  input  logic [SEQ_W-1:0] regrdy_seq,
  input  logic             release_valid,
  input  logic [SEQ_W-1:0] release_seq,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [SEQ_W-1:0] iss_seq,
  output logic             iss_store,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  output logic [CNT_W-1:0] cnt_loads,
  output logic [CNT_W-1:0] cnt_stores,
  output logic [CNT_W-1:0] cnt_conf_loads,
  output logic [CNT_W-1:0] cnt_conf_stores
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  typedef struct packed {
    logic             valid;
    logic [SEQ_W-1:0] seq;
    logic             store;
    logic             nonspec;
    logic             regs;
    logic             mem;
    logic             rdy;
    logic             linked;
    logic [IW-1:0]    link;
  } ent_t;

  ent_t tbl    [N];
  ent_t tbl_nx [N];

  logic [N-1:0]     valid_vec, rdy_vec, free_vec, prod_match, dup_match;
  logic [SEQ_W-1:0] seq_arr [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign valid_vec[g]  = tbl[g].valid;
    assign rdy_vec[g]    = tbl[g].valid && tbl[g].rdy;
    assign free_vec[g]   = !tbl[g].valid;
    assign seq_arr[g]    = tbl[g].seq;
    assign prod_match[g] = tbl[g].valid && tbl[g].store && (tbl[g].seq == ins_pred_seq);
    assign dup_match[g]  = tbl[g].valid && tbl[g].store && (tbl[g].seq == ins_seq);
  end

  logic          has_free, prod_hit, pick_hit;
  logic [IW-1:0] free_idx, prod_idx, pick_idx;

  mdu_first_set #(.N(N)) u_alloc (.req(free_vec),   .hit(has_free), .idx(free_idx));
  mdu_first_set #(.N(N)) u_prod  (.req(prod_match), .hit(prod_hit), .idx(prod_idx));
  mdu_oldest_pick #(.N(N), .SEQ_W(SEQ_W)) u_pick (
    .cand(rdy_vec), .seqs(seq_arr), .hit(pick_hit), .idx(pick_idx)
  );

  // Named events, also observed by the checker
  logic   evt_squash, evt_pop, evt_insert, pop_store, ins_linked, store_dup;
  place_e ins_place;

  assign evt_squash = sq_valid;
  assign ins_ready  = has_free;
  assign iss_valid  = pick_hit && !evt_squash;
  assign iss_seq    = seq_arr[pick_idx];
  assign iss_store  = tbl[pick_idx].store;
  assign evt_pop    = iss_valid && iss_ready;
  assign pop_store  = evt_pop && tbl[pick_idx].store;
  assign evt_insert = ins_valid && has_free && !evt_squash;
  assign store_dup  = |dup_match;
  assign ins_linked = evt_insert && !ins_nonspec && (ins_pred_seq != '0) && prod_hit &&
                      !(evt_pop && (prod_idx == pick_idx));
  assign ins_place  = place_of(ins_nonspec, ins_linked, ins_regs_ready);

  ent_t new_ent;
  always_comb begin
    new_ent         = '0;
    new_ent.valid   = 1'b1;
    new_ent.seq     = ins_seq;
    new_ent.store   = ins_store;
    new_ent.nonspec = ins_nonspec;
    new_ent.regs    = ins_regs_ready;
    new_ent.mem     = (ins_place != PLACE_LINKED);
    new_ent.rdy     = (ins_place == PLACE_READY);
    new_ent.linked  = (ins_place == PLACE_LINKED);
    new_ent.link    = prod_idx;
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      tbl_nx[i] = tbl[i];
      if (evt_squash) begin
        if (tbl[i].valid && seq_after(32'(tbl[i].seq), 32'(sq_seq))) tbl_nx[i] = '0;
      end else begin
        if (evt_pop && (pick_idx == IW'(i))) begin
          tbl_nx[i] = '0;
        end else if (tbl[i].valid && !tbl[i].rdy) begin
          if (pop_store && tbl[i].linked && (tbl[i].link == pick_idx)) begin
            tbl_nx[i].mem    = 1'b1;
            tbl_nx[i].linked = 1'b0;
          end
          if (regrdy_valid && (tbl[i].seq == regrdy_seq) && !tbl[i].nonspec)
            tbl_nx[i].regs = 1'b1;
          if (tbl[i].nonspec) begin
            if (release_valid && (tbl[i].seq == release_seq)) tbl_nx[i].rdy = 1'b1;
          end else if (tbl_nx[i].regs && tbl_nx[i].mem) begin
            tbl_nx[i].rdy = 1'b1;
          end
        end
        if (evt_insert && (free_idx == IW'(i))) tbl_nx[i] = new_ent;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) tbl[i] <= '0;
      else        tbl[i] <= tbl_nx[i];
    end
  end

  logic [3:0]            cnt_inc;
  logic [3:0][CNT_W-1:0] cnt_all;

  assign cnt_inc[0] = evt_insert && !ins_store;
  assign cnt_inc[1] = evt_insert && ins_store;
  assign cnt_inc[2] = ins_linked && !ins_store;
  assign cnt_inc[3] = ins_linked && ins_store;

  mdu_event_counters #(.NCNT(4), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .cnt(cnt_all)
  );

  assign cnt_loads       = cnt_all[0];
  assign cnt_stores      = cnt_all[1];
  assign cnt_conf_loads  = cnt_all[2];
  assign cnt_conf_stores = cnt_all[3];

endmodule

// File: rtl/mem_dep_sched_chk.sv
module mem_dep_sched_chk #(
  parameter int N     = 16,
  parameter int SEQ_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_valid,
  input logic             ins_ready,
  input logic             ins_store,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [SEQ_W-1:0] iss_seq,
  input logic             sq_valid,
  input logic [SEQ_W-1:0] sq_seq,
  input logic [N-1:0]     valid_vec,
  input logic             evt_insert,
  input logic             evt_pop,
  input logic             store_dup,
  input logic [CNT_W-1:0] cnt_loads,
  input logic [CNT_W-1:0] cnt_stores
);
  logic [CNT_W-1:0] tot_ins;
  assign tot_ins = cnt_loads + cnt_stores;

  assert_no_dup_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_insert && ins_store |-> !store_dup);

  assert_full_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !ins_ready && !sq_valid |=>
      $countones(valid_vec) <= $past($countones(valid_vec)));

  assert_squash_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |-> !evt_pop && !evt_insert && !iss_valid);

  assert_squash_trims_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |=> !iss_valid || (iss_seq <= $past(sq_seq)));

  assert_oldest_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready && !sq_valid |=>
      sq_valid || (iss_valid && (iss_seq <= $past(iss_seq))));

  assert_insert_counted_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_insert |=> tot_ins == $past(tot_ins) + CNT_W'(1));

  assert_idle_uncounted_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_insert |=> $stable(tot_ins));

endmodule

bind mem_dep_sched mem_dep_sched_chk #(.N(N), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .ins_store(ins_store), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_seq(iss_seq), .sq_valid(sq_valid), .sq_seq(sq_seq), .valid_vec(valid_vec),
  .evt_insert(evt_insert), .evt_pop(evt_pop), .store_dup(store_dup),
  .cnt_loads(cnt_loads), .cnt_stores(cnt_stores)
);

// File: tb/test_mem_dep_sched.sv
module test_mem_dep_sched;
  localparam int N = 16, SEQ_W = 8, CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 0, ins_store = 0, ins_regs_ready = 0, ins_nonspec = 0;
  logic [SEQ_W-1:0] ins_seq = '0, ins_pred_seq = '0;
  logic regrdy_valid = 0, release_valid = 0, iss_ready = 0, sq_valid = 0;
  logic [SEQ_W-1:0] regrdy_seq = '0, release_seq = '0, sq_seq = '0;
  logic ins_ready, iss_valid, iss_store;
  logic [SEQ_W-1:0] iss_seq;
  logic [CNT_W-1:0] cnt_loads, cnt_stores, cnt_conf_loads, cnt_conf_stores;

  always #5 clk = ~clk;

  mem_dep_sched #(.N(N), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) i_mem_dep_sched (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model, indexed by sequence number
  bit m_v[256], m_st[256], m_ns[256], m_rg[256], m_mm[256], m_rd[256], m_lk[256];
  int m_dep[256];
  int e_cnt[4];

  function automatic int m_occ();
    int c = 0;
    for (int s = 0; s < 256; s++) if (m_v[s]) c++;
    return c;
  endfunction

  function automatic int m_oldest();
    for (int s = 0; s < 256; s++) if (m_v[s] && m_rd[s]) return s;
    return -1;
  endfunction

  task automatic model_step();
    int occ = m_occ();
    int p = m_oldest();
    bit pop, prod, acc;
    if (sq_valid) begin
      for (int s = 0; s < 256; s++) if (s > int'(sq_seq)) m_v[s] = 0;
      return;
    end
    pop  = iss_ready && (p >= 0);
    acc  = ins_valid && (occ < N);
    prod = acc && !ins_nonspec && (ins_pred_seq != 0) && m_v[ins_pred_seq] &&
           m_st[ins_pred_seq] && !(pop && p == int'(ins_pred_seq));
    if (pop) begin
      m_v[p] = 0;
      if (m_st[p])
        for (int s = 0; s < 256; s++)
          if (m_v[s] && !m_rd[s] && m_lk[s] && m_dep[s] == p) begin m_mm[s] = 1; m_lk[s] = 0; end
    end
    if (regrdy_valid && m_v[regrdy_seq] && !m_rd[regrdy_seq] && !m_ns[regrdy_seq])
      m_rg[regrdy_seq] = 1;
    if (release_valid && m_v[release_seq] && !m_rd[release_seq] && m_ns[release_seq])
      m_rd[release_seq] = 1;
    for (int s = 0; s < 256; s++)
      if (m_v[s] && !m_rd[s] && !m_ns[s] && m_rg[s] && m_mm[s]) m_rd[s] = 1;
    if (acc) begin
      m_v[ins_seq] = 1; m_st[ins_seq] = ins_store; m_ns[ins_seq] = ins_nonspec;
      m_rg[ins_seq] = ins_regs_ready; m_mm[ins_seq] = !prod; m_lk[ins_seq] = prod;
      m_dep[ins_seq] = int'(ins_pred_seq);
      m_rd[ins_seq] = !ins_nonspec && !prod && ins_regs_ready;
      e_cnt[ins_store ? 1 : 0]++;
      if (prod) e_cnt[ins_store ? 3 : 2]++;
    end
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int p = m_oldest();
    chk(iss_valid, p >= 0, "R6 iss_valid");
    if (p >= 0) begin
      chk(iss_seq, p, "R6 iss_seq");
      chk(iss_store, m_st[p], "R6 iss_store");
    end
    chk(ins_ready, m_occ() < N, "R10 ins_ready");
    chk(cnt_loads, e_cnt[0] % 65536, "R11 loads");
    chk(cnt_stores, e_cnt[1] % 65536, "R11 stores");
    chk(cnt_conf_loads, e_cnt[2] % 65536, "R11 conf loads");
    chk(cnt_conf_stores, e_cnt[3] % 65536, "R11 conf stores");
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    ins_valid = 0; regrdy_valid = 0; release_valid = 0; sq_valid = 0; iss_ready = 0;
    #1 compare_all();
  endtask

  task automatic ins(input int s, input bit st, input bit rg, input bit ns, input int pr);
    ins_valid = 1; ins_seq = SEQ_W'(s); ins_store = st; ins_regs_ready = rg;
    ins_nonspec = ns; ins_pred_seq = SEQ_W'(pr);
    step();
  endtask
  task automatic regrdy(input int s);
    regrdy_valid = 1; regrdy_seq = SEQ_W'(s); step();
  endtask
  task automatic rel(input int s);
    release_valid = 1; release_seq = SEQ_W'(s); step();
  endtask
  task automatic pop();
    iss_ready = 1; step();
  endtask
  task automatic squash(input int s);
    sq_valid = 1; sq_seq = SEQ_W'(s); step();
  endtask
  task automatic expect_iss(input bit v, input int s, input bit st, input string tag);
    chk(iss_valid, v, {tag, " valid"});
    if (v) begin
      chk(iss_seq, s, {tag, " seq"});
      chk(iss_store, st, {tag, " store"});
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int nxt, c0;
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R12 reset state
    chk(iss_valid, 0, "R12 iss_valid");
    chk(ins_ready, 1, "R12 ins_ready");
    chk(cnt_loads + cnt_stores + cnt_conf_loads + cnt_conf_stores, 0, "R12 counters");

    // R1 direct to ready, R7 pop removes
    ins(1, 0, 1, 0, 0);      expect_iss(1, 1, 0, "R1");
    pop();                   expect_iss(0, 0, 0, "R7 removed");
    // R2 register wait
    ins(2, 1, 0, 0, 0);      expect_iss(0, 0, 0, "R2 waiting");
    regrdy(2);               expect_iss(1, 2, 1, "R2 released");
    // R3 linked to store 2
    ins(3, 0, 1, 0, 2);      expect_iss(1, 2, 1, "R3 dependent held");
    chk(cnt_conf_loads, 1, "R11 conflict load");
    pop();                   expect_iss(1, 3, 0, "R7 wake dependent");
    pop();
    // R5 non-speculative
    ins(4, 0, 1, 1, 0);      expect_iss(0, 0, 0, "R5 held");
    regrdy(4);               expect_iss(0, 0, 0, "R5 regrdy ignored");
    rel(4);                  expect_iss(1, 4, 0, "R5 release");
    pop();
    // R6 oldest wins, R8 squash, R9 priority
    ins(5, 0, 0, 0, 0);
    ins(6, 0, 1, 0, 0);      expect_iss(1, 6, 0, "R6 only ready");
    regrdy(5);               expect_iss(1, 5, 0, "R6 older first");
    c0 = cnt_loads;
    sq_valid = 1; sq_seq = 5; iss_ready = 1;
    ins_valid = 1; ins_seq = 7; ins_store = 0; ins_regs_ready = 1; ins_nonspec = 0; ins_pred_seq = 0;
    step();
    expect_iss(1, 5, 0, "R9 pop ignored");
    chk(cnt_loads, c0, "R9 insert ignored");
    pop();                   expect_iss(0, 0, 0, "R8 younger removed");
    // R3 unknown predicted producer
    ins(8, 0, 1, 0, 200);    expect_iss(1, 8, 0, "R3 untracked pred");
    pop();
    // R8 squash unlinks a dependent
    ins(20, 1, 0, 0, 0);
    ins(21, 0, 1, 0, 20);
    squash(20);
    regrdy(20);              expect_iss(1, 20, 1, "R8 producer kept");
    pop();                   expect_iss(0, 0, 0, "R8 no stale wake");
    // R4 non-speculative store acts as producer
    ins(40, 1, 0, 1, 0);
    ins(41, 0, 1, 0, 40);    expect_iss(0, 0, 0, "R4 linked to held store");
    rel(40);                 expect_iss(1, 40, 1, "R4 store released");
    pop();                   expect_iss(1, 41, 0, "R4 dependent woken");
    pop();
    // R10 capacity
    for (int k = 0; k < N; k++) ins(50 + k, 0, 0, 0, 0);
    chk(ins_ready, 0, "R10 full");
    c0 = cnt_loads;
    ins(70, 0, 1, 0, 0);     expect_iss(0, 0, 0, "R10 dropped");
    chk(cnt_loads, c0, "R10 not counted");
    squash(0);               chk(ins_ready, 1, "R8 all cleared");

    // Random phase
    nxt = 1;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      int occ = m_occ();
      if (nxt > 230 || ($urandom % 100) < 3) begin
        int s = (nxt > 230) ? 0 : int'($urandom % nxt);
        sq_valid = 1; sq_seq = SEQ_W'(s);
        nxt = s + 1;
      end else begin
        if (($urandom % 100) < 45) begin
          int r = $urandom % 4;
          ins_valid = 1; ins_seq = SEQ_W'(nxt); ins_store = $urandom % 2;
          ins_regs_ready = $urandom % 2; ins_nonspec = (($urandom % 10) == 0);
          ins_pred_seq = (r == 0) ? '0 : (r == 3) ? SEQ_W'($urandom) :
                         SEQ_W'(($urandom % nxt) + 1);
          if (occ < N) nxt++;
        end
        if (($urandom % 100) < 40) begin regrdy_valid = 1; regrdy_seq = SEQ_W'(($urandom % nxt) + 1); end
        if (($urandom % 100) < 15) begin release_valid = 1; release_seq = SEQ_W'(($urandom % nxt) + 1); end
        iss_ready = (($urandom % 100) < 55);
      end
      step();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule